// File: doc/BRIEF.md
# Configurable Minifloat Down-Converter

The block narrows IEEE-754 single-precision values into one of five small floating-point formats, picked per input by a select field. Each output word holds a sign bit, a biased exponent and a fraction with a hidden leading one. The word is right-aligned in a 16-bit result, and the bits above the selected width are zero. The exponent bias is either the format's default or a signed value supplied with the input. This lets a neural-network layer shift the representable range to suit its own data.

Three rounding policies are available: round-to-nearest-even, truncation, and stochastic rounding. Stochastic rounding draws its random bits from an internal seedable 16-bit LFSR. Results that are too large saturate to the largest finite magnitude. Results that are too small flush to signed zero. Two sticky flags record saturation and flushing. Inputs enter and results leave through valid/ready handshakes, with one register stage between them.

Top module: `mfp_down_cvt`

## Requirements
- R1: `fmt_sel_i` selects the format: 0 gives e=5, m=10, bias 15; 1 gives e=8, m=7, bias 127; 2 gives e=5, m=2, bias 15; 3 gives e=4, m=3, bias 7; 4 gives e=3, m=2, bias 3; codes 5 to 7 behave as 0. The result is `{sign, exponent[e], fraction[m]}` in bits e+m down to 0, and all higher bits are zero.
- R2: Mode 0, and the unused mode 3, round to nearest even. The fraction is incremented when the first discarded bit is one and either a later discarded bit or the kept LSB is one.
- R3: Mode 1 truncates. The discarded fraction bits are dropped.
- R4: Mode 2 rounds stochastically. The 16 LFSR bits are placed directly below the kept LSB and added to the discarded bits. A carry out of that sum increments the fraction.
- R5: The LFSR shifts left. Its new bit 0 is bit15^bit13^bit12^bit10. It resets to 0x0001. `seed_load_i` loads `seed_i`, and a zero seed loads 0x0001 instead. The LFSR advances once per accepted input, and the input uses the value held before that advance.
- R6: A rounding carry out of the fraction increments the exponent, and the overflow test follows that increment. If the exponent exceeds 2^e-2, or the input is infinite, the output is the sign, exponent 2^e-2 and an all-ones fraction. `ovf_o` is then set and stays set.
- R7: A rebiased exponent below 1 after rounding gives signed zero and sets the sticky flag `unf_o`. An FP32 zero or subnormal input also gives signed zero, and sets `unf_o` only when its fraction is nonzero. `flag_clr_i` clears both flags, but a flag set in the same cycle wins.
- R8: An FP32 NaN gives the sign, an all-ones exponent and a fraction with only its MSB set. It sets no flag.
- R9: While `bias_ovr_i` is high, the signed 10-bit `bias_val_i` replaces the default bias of the selected format.
- R10: An input is accepted on a rising edge with `in_valid_i` and `in_ready_o` high, and its result is valid after that edge. `in_ready_o` equals `!out_valid_o || out_ready_i`. A stalled result holds stable.
- R11: After reset, `out_valid_o`, `ovf_o` and `unf_o` are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word present |
| in_ready_o | output | 1 | Input can be taken |
| in_data_i | input | 32 | Single-precision operand |
| fmt_sel_i | input | 3 | Target format code |
| rnd_mode_i | input | 2 | Rounding policy |
| bias_ovr_i | input | 1 | Use bias_val_i as the bias |
| bias_val_i | input | 10 | Signed replacement bias |
| seed_load_i | input | 1 | Load the LFSR seed |
| seed_i | input | 16 | LFSR seed value |
| flag_clr_i | input | 1 | Clear the sticky flags |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Result consumed |
| out_data_o | output | 16 | Right-aligned result |
| ovf_o | output | 1 | Sticky saturation flag |
| unf_o | output | 1 | Sticky flush flag |

## Verification
The result, both sticky flags and the LFSR step all take effect on the rising edge that accepts an input, so the first falling edge after that edge is where each of them is due. The bench drives every operand on a falling edge and waits through exactly one rising edge. It then compares data and flags on the next falling edge against an arithmetic model that keeps its own LFSR copy. The stall test holds `out_ready_i` low across two falling edges. It checks that the first result stays put and that a second offered input is taken only on the edge that releases the stall.

// File: rtl/mfp_pkg.sv
package mfp_pkg;

  typedef enum logic [1:0] {
    RND_NEAR  = 2'd0,
    RND_TRUNC = 2'd1,
    RND_STOCH = 2'd2,
    RND_ALT   = 2'd3
  } rnd_mode_e;

  typedef struct packed {
    logic [3:0] exp_w;
    logic [3:0] man_w;
    logic [7:0] bias;
  } fmt_t;

  function automatic fmt_t fmt_lookup(input logic [2:0] sel);
    fmt_t f;
    unique case (sel)
      3'd1:    f = '{exp_w: 4'd8, man_w: 4'd7,  bias: 8'd127};
      3'd2:    f = '{exp_w: 4'd5, man_w: 4'd2,  bias: 8'd15};
      3'd3:    f = '{exp_w: 4'd4, man_w: 4'd3,  bias: 8'd7};
      3'd4:    f = '{exp_w: 4'd3, man_w: 4'd2,  bias: 8'd3};
      default: f = '{exp_w: 4'd5, man_w: 4'd10, bias: 8'd15};
    endcase
    return f;
  endfunction

endpackage

// File: rtl/mfp_lfsr.sv
module mfp_lfsr #(
  parameter int          W      = 16,
  parameter logic [W-1:0] TAPS  = 16'hB400,
  parameter logic [W-1:0] RST_V = 16'h0001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb      = ^(state_q & TAPS);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state_q <= RST_V;
    else if (load_i)     state_q <= (seed_i == '0) ? RST_V : seed_i;
    else if (step_i)     state_q <= {state_q[W-2:0], fb};
  end
endmodule

// File: rtl/mfp_cvt_core.sv
module mfp_cvt_core
  import mfp_pkg::*;
#(
  parameter int IN_EXP_W = 8,
  parameter int IN_MAN_W = 23,
  parameter int OUT_W    = 16,
  parameter int BIAS_W   = 10,
  parameter int RND_W    = 16
) (
  input  logic [IN_EXP_W+IN_MAN_W:0] data_i,
  input  fmt_t                       fmt_i,
  input  logic [BIAS_W-1:0]          bias_i,
  input  logic [1:0]                 mode_i,
  input  logic [RND_W-1:0]           rnd_i,
  output logic [OUT_W-1:0]           res_o,
  output logic                       ovf_o,
  output logic                       unf_o
);
  localparam int IN_W    = 1 + IN_EXP_W + IN_MAN_W;
  localparam int IN_BIAS = 2 ** (IN_EXP_W - 1) - 1;
  localparam int EW      = ((BIAS_W > IN_EXP_W) ? BIAS_W : IN_EXP_W) + 2;
  localparam int SH_W    = $clog2(IN_MAN_W + 1);

  logic                 sgn, in_zs, in_special, in_nan;
  logic [IN_EXP_W-1:0]  exp_in;
  logic [IN_MAN_W-1:0]  man_in, kept, rem_al, rnd_al, mask, frac_r, frac_f;
  logic [SH_W-1:0]      dsc;
  logic                 guard, sticky, up, carry, zero_out;
  logic signed [EW-1:0] te_pre, te, max_code;
  logic [7:0]           exp_f;
  logic [4:0]           sgn_pos;

  assign sgn        = data_i[IN_W-1];
  assign exp_in     = data_i[IN_W-2 -: IN_EXP_W];
  assign man_in     = data_i[IN_MAN_W-1:0];
  assign in_zs      = (exp_in == '0);
  assign in_special = &exp_in;
  assign in_nan     = in_special && (man_in != '0);

  // kept fraction and left-aligned remainder
  assign dsc    = SH_W'(IN_MAN_W) - SH_W'(fmt_i.man_w);
  assign kept   = man_in >> dsc;
  assign rem_al = man_in << fmt_i.man_w;
  assign mask   = (IN_MAN_W'(1) << fmt_i.man_w) - IN_MAN_W'(1);
  assign guard  = rem_al[IN_MAN_W-1];
  assign sticky = |rem_al[IN_MAN_W-2:0];
  assign rnd_al = {rnd_i, {(IN_MAN_W-RND_W){1'b0}}};

  always_comb begin
    unique case (rnd_mode_e'(mode_i))
      RND_TRUNC: up = 1'b0;
      RND_STOCH: up = (rem_al > ~rnd_al);  // carry out of rem_al + rnd_al
      default:   up = guard && (sticky || kept[0]);
    endcase
  end

  assign carry  = up && (kept == mask);
  assign frac_r = (kept + IN_MAN_W'(up)) & mask;

  assign te_pre   = $signed({{(EW-IN_EXP_W){1'b0}}, exp_in}) - EW'(IN_BIAS)
                  + $signed({{(EW-BIAS_W){bias_i[BIAS_W-1]}}, bias_i});
  assign te       = te_pre + EW'(carry);
  assign max_code = $signed((EW'(1) << fmt_i.exp_w) - EW'(2));

  assign ovf_o    = !in_nan && !in_zs && (in_special || (te > max_code));
  assign unf_o    = in_zs ? (man_in != '0) : (!in_special && !ovf_o && (te < EW'(1)));
  assign zero_out = in_zs || unf_o;

  always_comb begin
    if (in_nan) begin
      exp_f  = (8'(1) << fmt_i.exp_w) - 8'd1;
      frac_f = IN_MAN_W'(1) << (fmt_i.man_w - 4'd1);
    end else if (ovf_o) begin
      exp_f  = 8'(max_code);
      frac_f = mask;
    end else if (zero_out) begin
      exp_f  = '0;
      frac_f = '0;
    end else begin
      exp_f  = 8'(te);
      frac_f = frac_r;
    end
  end

  assign sgn_pos = {1'b0, fmt_i.exp_w} + {1'b0, fmt_i.man_w};
  assign res_o   = (OUT_W'(sgn) << sgn_pos)
                 | (OUT_W'(exp_f) << fmt_i.man_w)
                 | OUT_W'(frac_f);
endmodule

// File: rtl/mfp_down_cvt.sv
module mfp_down_cvt
  import mfp_pkg::*;
#(
  parameter int OUT_W  = 16,
  parameter int BIAS_W = 10,
  parameter int RND_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [31:0]       in_data_i,
  input  logic [2:0]        fmt_sel_i,
  input  logic [1:0]        rnd_mode_i,
  input  logic              bias_ovr_i,
  input  logic [BIAS_W-1:0] bias_val_i,
  input  logic              seed_load_i,
  input  logic [RND_W-1:0]  seed_i,
  input  logic              flag_clr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OUT_W-1:0]  out_data_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic              accept;
  fmt_t              fmt;
  logic [BIAS_W-1:0] bias_eff;
  logic [RND_W-1:0]  rnd;
  logic [OUT_W-1:0]  res;
  logic              res_ovf, res_unf;
  logic              valid_q, ovf_q, unf_q;
  logic [OUT_W-1:0]  data_q;

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;
  assign fmt        = fmt_lookup(fmt_sel_i);
  assign bias_eff   = bias_ovr_i ? bias_val_i : BIAS_W'(fmt.bias);

  mfp_lfsr #(.W(RND_W)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (seed_load_i),
    .seed_i  (seed_i),
    .step_i  (accept),
    .state_o (rnd)
  );

  mfp_cvt_core #(
    .OUT_W  (OUT_W),
    .BIAS_W (BIAS_W),
    .RND_W  (RND_W)
  ) u_core (
    .data_i (in_data_i),
    .fmt_i  (fmt),
    .bias_i (bias_eff),
    .mode_i (rnd_mode_i),
    .rnd_i  (rnd),
    .res_o  (res),
    .ovf_o  (res_ovf),
    .unf_o  (res_unf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      data_q  <= res;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  // sticky flags: a new event wins over a clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= (accept && res_ovf) || (ovf_q && !flag_clr_i);
      unf_q <= (accept && res_unf) || (unf_q && !flag_clr_i);
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
  assign ovf_o       = ovf_q;
  assign unf_o       = unf_q;
endmodule

// File: rtl/mfp_down_cvt_chk.sv
module mfp_down_cvt_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [OUT_W-1:0] out_data_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic             flag_clr_i
);
  p_stall_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  p_stall_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_latency_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  p_ovf_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !flag_clr_i) |=> ovf_o);

  p_unf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_o && !flag_clr_i) |=> unf_o);

  p_flag_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !(in_valid_i && in_ready_o)) |=> (!ovf_o && !unf_o));
endmodule

bind mfp_down_cvt mfp_down_cvt_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .ovf_o       (ovf_o),
  .unf_o       (unf_o),
  .flag_clr_i  (flag_clr_i)
);

// File: tb/mfp_down_cvt_test.sv
module mfp_down_cvt_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [2:0]  fmt_sel = '0;
  logic [1:0]  rnd_mode = '0;
  logic        bias_ovr = 1'b0;
  logic [9:0]  bias_val = '0;
  logic        seed_load = 1'b0;
  logic [15:0] seed = '0;
  logic        flag_clr = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        ovf, unf;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_lfsr = 16'h0001;
  bit m_ovf = 1'b0, m_unf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfp_down_cvt uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .fmt_sel_i(fmt_sel), .rnd_mode_i(rnd_mode),
    .bias_ovr_i(bias_ovr), .bias_val_i(bias_val), .seed_load_i(seed_load),
    .seed_i(seed), .flag_clr_i(flag_clr), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .out_data_o(out_data), .ovf_o(ovf), .unf_o(unf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  function automatic logic [15:0] ref_cvt(input logic [31:0] x, input int sel, input int mode,
                                          input bit ovr, input int bval, input logic [15:0] rnd,
                                          output bit o, output bit u);
    int e, m, b, bias, s, ex, f, sig, sh, q, r, half, te;
    case (sel)
      1: begin e = 8; m = 7; b = 127; end
      2: begin e = 5; m = 2; b = 15; end
      3: begin e = 4; m = 3; b = 7; end
      4: begin e = 3; m = 2; b = 3; end
      default: begin e = 5; m = 10; b = 15; end
    endcase
    bias = ovr ? bval : b;
    s = int'(x[31]); ex = int'(x[30:23]); f = int'(x[22:0]);
    o = 1'b0; u = 1'b0;
    if (ex == 255 && f != 0) return 16'((s << (e+m)) | (((1 << e) - 1) << m) | (1 << (m-1)));
    if (ex == 0) begin
      u = (f != 0);
      return 16'(s << (e+m));
    end
    sig = f + (1 << 23); sh = 23 - m;
    q = sig >> sh; r = sig - (q << sh); half = 1 << (sh - 1);
    if (mode == 1) q = q;
    else if (mode == 2) begin
      if ((r << m) + (int'(rnd) << 7) >= (1 << 23)) q++;
    end else if (r > half || (r == half && (q % 2) == 1)) q++;
    te = ex - 127 + bias;
    if (q >= (1 << (m+1))) begin q = q >> 1; te++; end
    if (ex == 255 || te > (1 << e) - 2) begin
      o = 1'b1;
      return 16'((s << (e+m)) | (((1 << e) - 2) << m) | ((1 << m) - 1));
    end
    if (te < 1) begin
      u = 1'b1;
      return 16'(s << (e+m));
    end
    return 16'((s << (e+m)) | (te << m) | (q - (1 << m)));
  endfunction

  task automatic tx(input logic [31:0] x, input int sel, input int mode, input bit ovr,
                    input int bval, input string force_tag);
    bit o, u;
    logic [15:0] e_res;
    string tag;
    e_res = ref_cvt(x, sel, mode, ovr, bval, m_lfsr, o, u);
    in_data = x; fmt_sel = 3'(sel); rnd_mode = 2'(mode);
    bias_ovr = ovr; bias_val = 10'(bval); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    m_lfsr = lfsr_next(m_lfsr);
    m_ovf |= o; m_unf |= u;
    if (force_tag != "") tag = force_tag;
    else if (x[30:23] == 8'hFF && x[22:0] != 0) tag = "R8";
    else if (o) tag = "R6";
    else if (u) tag = "R7";
    else if (ovr) tag = "R9";
    else if (mode == 1) tag = "R3";
    else if (mode == 2) tag = "R4";
    else tag = "R2";
    chk("R10", 32'(out_valid), 32'd1, "valid");
    chk(tag, 32'(out_data), 32'(e_res), $sformatf("data x=%h sel=%0d mode=%0d", x, sel, mode));
    chk("R6", 32'(ovf), 32'(m_ovf), "ovf flag");
    chk("R7", 32'(unf), 32'(m_unf), "unf flag");
  endtask

  function automatic logic [7:0] pick_e(input int k);
    case (k)
      0: return 8'd0;
      1: return 8'd1;
      2: return 8'd2;
      3: return 8'd254;
      4: return 8'd255;
      default: return 8'(101 + k);
    endcase
  endfunction

  function automatic logic [22:0] pick_f(input int j);
    case (j)
      0: return 23'h000000;
      1: return 23'h000001;
      2: return 23'h400000;
      3: return 23'h7FFFFF;
      4: return 23'h200000;
      5: return 23'h1FFFFF;
      6: return 23'h155555;
      default: return 23'h2AAAAA;
    endcase
  endfunction

  task automatic sweep(input int sel, input int mode, input bit ovr, input int bval);
    for (int k = 0; k < 48; k++)
      for (int j = 0; j < 8; j++)
        tx({1'(k ^ j), pick_e(k), pick_f(j)}, sel, mode, ovr, bval, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", 32'(out_valid), 32'd0, "valid after reset");
    chk("R11", 32'(in_ready), 32'd1, "ready after reset");
    chk("R11", 32'({ovf, unf}), 32'd0, "flags after reset");

    // R5 seed load on an idle cycle
    seed = 16'hACE1; seed_load = 1'b1;
    @(posedge clk); @(negedge clk);
    seed_load = 1'b0; m_lfsr = 16'hACE1;

    // R1 R2 R3 R4: every format under every rounding policy
    for (int sel = 0; sel < 5; sel++)
      for (int mode = 0; mode < 3; mode++)
        sweep(sel, mode, 1'b0, 0);

    // R1 codes 5..7 alias format 0, R2 mode 3 aliases mode 0
    for (int sel = 5; sel < 8; sel++)
      for (int k = 0; k < 48; k++)
        tx({1'b0, pick_e(k), pick_f(k % 8)}, sel, 3, 1'b0, 0, "R1");

    // R9 bias override, positive and negative
    sweep(4, 0, 1'b1, 10);
    sweep(4, 2, 1'b1, -3);
    sweep(3, 0, 1'b1, 100);

    // R7 clear of sticky flags
    @(negedge clk);
    flag_clr = 1'b1;
    @(posedge clk); @(negedge clk);
    flag_clr = 1'b0; m_ovf = 1'b0; m_unf = 1'b0;
    chk("R7", 32'({ovf, unf}), 32'd0, "flags after clear");

    // R5 zero seed loads 0x0001, then stochastic results follow it
    seed = 16'h0000; seed_load = 1'b1;
    @(posedge clk); @(negedge clk);
    seed_load = 1'b0; m_lfsr = 16'h0001;
    for (int j = 0; j < 40; j++)
      tx({1'b0, 8'd130, pick_f(j % 8) ^ 23'(j * 977)}, 1, 2, 1'b0, 0, "R5");

    // R10 backpressure
    @(negedge clk);
    begin
      logic [15:0] exp_a, exp_b;
      bit o, u;
      exp_a = ref_cvt(32'h3FC00000, 0, 0, 1'b0, 0, m_lfsr, o, u);
      exp_b = ref_cvt(32'hC0490FDB, 0, 0, 1'b0, 0, lfsr_next(m_lfsr), o, u);
      out_ready = 1'b0;
      in_data = 32'h3FC00000; fmt_sel = 3'd0; rnd_mode = 2'd0; bias_ovr = 1'b0; in_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      in_data = 32'hC0490FDB;
      chk("R10", 32'(out_valid), 32'd1, "stall valid");
      chk("R10", 32'(in_ready), 32'd0, "stall ready");
      chk("R10", 32'(out_data), 32'(exp_a), "stall data 1");
      @(posedge clk); @(negedge clk);
      chk("R10", 32'(out_data), 32'(exp_a), "stall data 2");
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      chk("R10", 32'(out_data), 32'(exp_b), "second after release");
      @(posedge clk); @(negedge clk);
      chk("R10", 32'(out_valid), 32'd0, "drained");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule